// File: doc/BRIEF.md
# Two-Wire Slave Switch-Control Register

This block is a two-wire (I2C-compatible) slave that holds one 8-bit register whose bits each enable one analog switch. A fast system clock oversamples the serial clock and data lines. Both lines pass through a two-flop synchronizer and a consecutive-sample deglitcher before any edge is decoded. The block recognises START and STOP conditions. It compares the first byte of a transfer against its own 7-bit address. That address is a fixed 5-bit prefix, set by a parameter, followed by two strap inputs.

When the address matches, the slave acknowledges and then either takes write bytes into the register or shifts the register out to the master. The data line is driven only through an active-low pull-down enable; the clock line is an input only. Every accepted write byte appears on the register output at once, together with a one-cycle update strobe. Downstream switch drivers can therefore act on each byte of a burst.

Top module: `swreg_top`

## Requirements
- R1: While `rstN` is low, and after it is released, `switchState` is 8'h00, `updateStrobe` is 0 and `sdaOeN` is 1 (bus released). The register stays zero until a write byte completes, and a read in that state returns 8'h00.
- R2: The own address is {PREFIX, strapA1, strapA0}, with the prefix default 5'b10011. When the seven address bits (sent MSB first, before the R/W bit) match, the slave holds `sdaOeN` low through the 9th SCL pulse of the address byte. `sdaOeN` changes only while the filtered SCL is low.
- R3: On an address mismatch, the slave acknowledges neither the address nor any later byte. It leaves `switchState` unchanged and raises no strobe until the next START.
- R4: With R/W = 0, each data byte is received MSB first and acknowledged. After its 8th bit the byte is loaded into `switchState`, and `updateStrobe` is high for exactly one clock.
- R5: Several data bytes in one addressed write each update `switchState` in turn. Each byte gives its own single strobe.
- R6: With R/W = 1, the slave shifts `switchState` out MSB first. A master ACK (SDA low on the 9th pulse) makes it send the register again. A master NACK makes it release SDA and stay silent until a START.
- R7: A repeated START, at any point including mid-byte, restarts address decoding. A partial byte cut off by it is discarded.
- R8: A STOP returns the slave to idle. A data byte cut short by a STOP does not change `switchState` and raises no strobe.
- R9: High or low pulses on SCL or SDA shorter than GLITCH_NS (default 50 ns at a 125 MHz clock) are not seen. A short SCL pulse adds no bit, and a short SDA dip while SCL is high is not taken as START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaOeN | output | 1 | Data line pull-down enable, 0 drives the line low |
| strapA1 | input | 1 | Strap for address bit 1 |
| strapA0 | input | 1 | Strap for address bit 0 (LSB) |
| switchState | output | 8 | Switch-control register, bit n enables switch n |
| updateStrobe | output | 1 | One-cycle pulse when switchState takes a new write byte |

## Verification
The hardest states to reach from the ports are interrupted transfers. These are a repeated START or STOP that lands in the middle of a data byte, and a glitch that would look like an extra SCL edge or a false START if it got through. A bit-level bus master in the bench builds these directly. It truncates bytes after four bits, and it injects three-cycle SCL and SDA pulses inside a byte that must still arrive intact. After each case the bench looks at the register value and the strobe count to show that nothing moved.

// File: rtl/swreg_pkg.sv
package swreg_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  // Commands from control to datapath: pulses plus two drive levels
  typedef struct packed {
    logic shiftRx;
    logic commit;
    logic loadTx;
    logic shiftTx;
    logic ackLow;
    logic txEn;
  } ctrlCmd_t;

  // Bus events from datapath to control
  typedef struct packed {
    logic              sclRise;
    logic              sclFall;
    logic              startSeen;
    logic              stopSeen;
    logic              sdaBit;
    logic [BYTE_W-1:0] rxByte;
  } busEvt_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } phase_t;

endpackage

// File: rtl/swreg_deglitch.sv
module swreg_deglitch #(
  parameter int unsigned HOLD = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);

  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      runCnt   <= '0;
      cleanOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] != cleanOut) begin
        if (runCnt == CW'(HOLD - 1)) begin
          cleanOut <= syncQ[1];
          runCnt   <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        runCnt <= '0;
      end
    end
  end

  // R9: the clean line only ever moves toward the synchronized input level
  a_r9_follows_input: assert property (@(posedge clk) disable iff (!rstN)
    (cleanOut != $past(cleanOut)) |-> (cleanOut == $past(syncQ[1])));

endmodule

// File: rtl/swreg_datapath.sv
module swreg_datapath
  import swreg_pkg::*;
#(
  parameter int unsigned FILT_LEN = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctrlCmd_t          cmd,
  output busEvt_t           evt,
  output logic [BYTE_W-1:0] switchState,
  output logic              updateStrobe,
  output logic              sdaOeN
);

  logic [1:0] rawLines;
  logic [1:0] cleanLines;
  logic       sclF, sdaF, sclPrev, sdaPrev;
  logic [BYTE_W-1:0] rxShift, txShift;

  assign rawLines = {sdaIn, sclIn};

  for (genvar i = 0; i < 2; i++) begin : g_line
    swreg_deglitch #(.HOLD(FILT_LEN)) u_dg (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (rawLines[i]),
      .cleanOut(cleanLines[i])
    );
  end

  assign sclF = cleanLines[0];
  assign sdaF = cleanLines[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  assign evt.sclRise   = sclF & ~sclPrev;
  assign evt.sclFall   = ~sclF & sclPrev;
  assign evt.startSeen = sclF & sclPrev & ~sdaF & sdaPrev;
  assign evt.stopSeen  = sclF & sclPrev & sdaF & ~sdaPrev;
  assign evt.sdaBit    = sdaF;
  assign evt.rxByte    = {rxShift[BYTE_W-2:0], sdaF};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift      <= '0;
      txShift      <= '0;
      switchState  <= '0;
      updateStrobe <= 1'b0;
    end else begin
      if (cmd.shiftRx) rxShift <= evt.rxByte;
      if (cmd.commit)  switchState <= evt.rxByte;
      updateStrobe <= cmd.commit;
      if (cmd.loadTx)       txShift <= switchState;
      else if (cmd.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  assign sdaOeN = ~(cmd.ackLow | (cmd.txEn & ~txShift[BYTE_W-1]));

  // R4: strobe is a single-cycle pulse
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    updateStrobe |=> !updateStrobe);

  // R4: register never moves without its strobe
  a_r4_state_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (switchState != $past(switchState)) |-> updateStrobe);

  // R2: our drive on SDA only changes while filtered SCL is low
  a_r2_drive_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOeN != $past(sdaOeN)) |-> !sclF);

endmodule

// File: rtl/swreg_control.sv
module swreg_control
  import swreg_pkg::*;
#(
  parameter logic [4:0] PREFIX = 5'b10011
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     strapA1,
  input  logic     strapA0,
  input  busEvt_t  evt,
  output ctrlCmd_t cmd
);

  phase_t           phase;
  logic [CNT_W-1:0] bitCnt;
  logic             rwBit;
  logic             ackPhase;
  logic [ADDR_W-1:0] ownAddr;

  assign ownAddr = {PREFIX, strapA1, strapA0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= ST_IDLE;
      bitCnt   <= '0;
      rwBit    <= 1'b0;
      ackPhase <= 1'b0;
      cmd      <= '0;
    end else begin
      cmd.shiftRx <= 1'b0;
      cmd.commit  <= 1'b0;
      cmd.loadTx  <= 1'b0;
      cmd.shiftTx <= 1'b0;
      if (evt.startSeen || evt.stopSeen) begin
        phase      <= evt.startSeen ? ST_ADDR : ST_IDLE;
        bitCnt     <= '0;
        ackPhase   <= 1'b0;
        cmd.ackLow <= 1'b0;
        cmd.txEn   <= 1'b0;
      end else begin
        case (phase)
          ST_ADDR, ST_WR: begin
            if (evt.sclRise) begin
              cmd.shiftRx <= 1'b1;
              if (bitCnt == CNT_W'(BYTE_W - 1)) begin
                bitCnt <= '0;
                if (phase == ST_ADDR) begin
                  rwBit <= evt.rxByte[0];
                  phase <= (evt.rxByte[BYTE_W-1:1] == ownAddr) ? ST_ADDR_ACK : ST_IDLE;
                end else begin
                  cmd.commit <= 1'b1;
                  phase      <= ST_WR_ACK;
                end
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end
          ST_ADDR_ACK, ST_WR_ACK: begin
            if (evt.sclFall) begin
              if (!ackPhase) begin
                ackPhase   <= 1'b1;
                cmd.ackLow <= 1'b1;
              end else begin
                ackPhase   <= 1'b0;
                cmd.ackLow <= 1'b0;
                if (phase == ST_ADDR_ACK && rwBit) begin
                  phase      <= ST_RD;
                  cmd.loadTx <= 1'b1;
                  cmd.txEn   <= 1'b1;
                end else begin
                  phase <= ST_WR;
                end
              end
            end
          end
          ST_RD: begin
            if (evt.sclRise) bitCnt <= bitCnt + 1'b1;
            if (evt.sclFall) begin
              if (bitCnt == CNT_W'(BYTE_W)) begin
                bitCnt   <= '0;
                cmd.txEn <= 1'b0;
                phase    <= ST_RD_ACK;
              end else begin
                cmd.shiftTx <= 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (evt.sclRise) begin
              if (evt.sdaBit) phase <= ST_IDLE;
              else            ackPhase <= 1'b1;
            end else if (evt.sclFall && ackPhase) begin
              ackPhase   <= 1'b0;
              cmd.loadTx <= 1'b1;
              cmd.txEn   <= 1'b1;
              phase      <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6: acknowledge drive and read drive never overlap
  a_r6_ack_tx_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.ackLow && cmd.txEn));

  // R3: an idle (unaddressed) slave drives nothing
  a_r3_idle_silent: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_IDLE) |-> (!cmd.ackLow && !cmd.txEn));

  // R5: a register load only happens at the end of a write byte
  a_r5_commit_in_write: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |-> (phase == ST_WR_ACK));

endmodule

// File: rtl/swreg_top.sv
module swreg_top
  import swreg_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned GLITCH_NS = 50,
  parameter logic [4:0]  PREFIX    = 5'b10011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOeN,
  input  logic              strapA1,
  input  logic              strapA0,
  output logic [BYTE_W-1:0] switchState,
  output logic              updateStrobe
);

  localparam int unsigned CYC_NS_X1000 = (CLK_HZ / 1_000_000) * GLITCH_NS;
  localparam int unsigned FILT_RAW     = (CYC_NS_X1000 + 999) / 1000;
  localparam int unsigned FILT_LEN     = (FILT_RAW < 1) ? 1 : FILT_RAW;

  ctrlCmd_t cmd;
  busEvt_t  evt;

  swreg_datapath #(.FILT_LEN(FILT_LEN)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .cmd         (cmd),
    .evt         (evt),
    .switchState (switchState),
    .updateStrobe(updateStrobe),
    .sdaOeN      (sdaOeN)
  );

  swreg_control #(.PREFIX(PREFIX)) u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .strapA1(strapA1),
    .strapA0(strapA0),
    .evt    (evt),
    .cmd    (cmd)
  );

endmodule

// File: tb/sim_swreg_top.sv
`timescale 1ns/1ps
module sim_swreg_top;

  localparam int Q = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic sdaLine;
  logic sdaOeN;
  logic [7:0] switchState;
  logic updateStrobe;
  int checks = 0;
  int errors = 0;
  int strobeCnt = 0;

  always #4 clk = ~clk;

  assign sdaLine = mSda & sdaOeN;

  swreg_top u0 (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaOeN(sdaOeN),
    .strapA1(1'b1), .strapA0(1'b0),
    .switchState(switchState), .updateStrobe(updateStrobe)
  );

  always @(posedge clk) if (updateStrobe === 1'b1) strobeCnt++;

  // {addr7, expectAck, data, expectedState}
  localparam logic [23:0] VEC [8] = '{
    {7'h4E, 1'b1, 8'hA5, 8'hA5},
    {7'h4E, 1'b1, 8'h00, 8'h00},
    {7'h4F, 1'b0, 8'hFF, 8'h00},
    {7'h4E, 1'b1, 8'h81, 8'h81},
    {7'h46, 1'b0, 8'h3C, 8'h81},
    {7'h4C, 1'b0, 8'h55, 8'h81},
    {7'h4E, 1'b1, 8'h7E, 8'h7E},
    {7'h4E, 1'b1, 8'hFF, 8'hFF}
  };

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic startCond();
    mSda = 1'b1; scl = 1'b1; waitQ(Q);
    mSda = 1'b0; waitQ(Q);
    scl = 1'b0; waitQ(Q);
  endtask

  task automatic repStart();
    mSda = 1'b1; waitQ(Q);
    scl = 1'b1; waitQ(Q);
    mSda = 1'b0; waitQ(Q);
    scl = 1'b0; waitQ(Q);
  endtask

  task automatic stopCond();
    mSda = 1'b0; waitQ(Q);
    scl = 1'b1; waitQ(Q);
    mSda = 1'b1; waitQ(Q);
  endtask

  task automatic sendBit(input logic b);
    mSda = b; waitQ(Q);
    scl = 1'b1; waitQ(2 * Q);
    scl = 1'b0; waitQ(Q);
  endtask

  task automatic readBit(output logic b);
    mSda = 1'b1; waitQ(Q);
    scl = 1'b1; waitQ(Q);
    b = sdaLine; waitQ(Q);
    scl = 1'b0; waitQ(Q);
  endtask

  task automatic writeByte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    readBit(b);
    acked = ~b;
  endtask

  task automatic readByte(input logic masterNack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    sendBit(masterNack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a1, a2;
    logic [7:0] rd;
    int sc;

    // R1: reset state
    waitQ(10);
    check("R1 state in reset", switchState, 8'h00);
    check("R1 strobe in reset", updateStrobe, 1'b0);
    check("R1 sda released in reset", sdaOeN, 1'b1);
    rstN = 1'b1;
    waitQ(20);
    check("R1 state after reset", switchState, 8'h00);

    // R1: read before any write returns zero
    startCond();
    writeByte({7'h4E, 1'b1}, a1);
    check("R2 read address ack", a1, 1'b1);
    readByte(1'b1, rd);
    stopCond();
    check("R1 readback after reset", rd, 8'h00);

    // Table walk: R2/R3/R4
    for (int k = 0; k < 8; k++) begin
      sc = strobeCnt;
      startCond();
      writeByte({VEC[k][23:17], 1'b0}, a1);
      check(VEC[k][16] ? "R2 address ack" : "R3 mismatch no ack", a1, VEC[k][16]);
      writeByte(VEC[k][15:8], a2);
      check(VEC[k][16] ? "R4 data ack" : "R3 data no ack", a2, VEC[k][16]);
      stopCond();
      check(VEC[k][16] ? "R4 state" : "R3 state held", switchState, VEC[k][7:0]);
      check(VEC[k][16] ? "R4 one strobe" : "R3 no strobe", strobeCnt - sc, VEC[k][16] ? 1 : 0);
    end

    // R5: burst write
    sc = strobeCnt;
    startCond();
    writeByte({7'h4E, 1'b0}, a1);
    writeByte(8'h11, a2);
    check("R5 byte1 ack", a2, 1'b1);
    check("R5 byte1 state", switchState, 8'h11);
    writeByte(8'h22, a2);
    check("R5 byte2 state", switchState, 8'h22);
    writeByte(8'h33, a2);
    check("R5 byte3 ack", a2, 1'b1);
    stopCond();
    check("R5 final state", switchState, 8'h33);
    check("R5 three strobes", strobeCnt - sc, 3);

    // R6: read with master ACK then NACK
    startCond();
    writeByte({7'h4E, 1'b1}, a1);
    check("R6 read address ack", a1, 1'b1);
    readByte(1'b0, rd);
    check("R6 first read", rd, 8'h33);
    readByte(1'b1, rd);
    check("R6 second read", rd, 8'h33);
    check("R6 released after nack", sdaOeN, 1'b1);
    readBit(a1);
    check("R6 silent after nack", a1, 1'b1);
    stopCond();

    // R7: repeated START after mismatch
    sc = strobeCnt;
    startCond();
    writeByte({7'h4F, 1'b0}, a1);
    check("R7 mismatch before restart", a1, 1'b0);
    repStart();
    writeByte({7'h4E, 1'b0}, a1);
    check("R7 ack after restart", a1, 1'b1);
    writeByte(8'h5A, a2);
    stopCond();
    check("R7 state after restart", switchState, 8'h5A);

    // R7: repeated START mid data byte
    startCond();
    writeByte({7'h4E, 1'b0}, a1);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    repStart();
    writeByte({7'h4E, 1'b0}, a1);
    writeByte(8'h0F, a2);
    stopCond();
    check("R7 partial byte dropped", switchState, 8'h0F);
    check("R7 strobe count", strobeCnt - sc, 2);

    // R8: STOP mid byte
    sc = strobeCnt;
    startCond();
    writeByte({7'h4E, 1'b0}, a1);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    stopCond();
    check("R8 state held on stop", switchState, 8'h0F);
    check("R8 no strobe on stop", strobeCnt - sc, 0);

    // R9: glitches within a write of 8'hC3
    sc = strobeCnt;
    startCond();
    writeByte({7'h4E, 1'b0}, a1);
    mSda = 1'b1; waitQ(Q);
    scl = 1'b1; waitQ(Q);
    mSda = 1'b0; waitQ(3);
    mSda = 1'b1; waitQ(Q);
    scl = 1'b0; waitQ(Q);
    sendBit(1'b1);
    scl = 1'b1; waitQ(3);
    scl = 1'b0; waitQ(Q);
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b0); sendBit(1'b0);
    sendBit(1'b1); sendBit(1'b1);
    readBit(a2);
    stopCond();
    check("R9 glitched byte ack", a2, 1'b0);
    check("R9 glitched byte value", switchState, 8'hC3);
    check("R9 one strobe", strobeCnt - sc, 1);

    // R1: reset mid-run clears register
    rstN = 1'b0; waitQ(5);
    check("R1 reset clears", switchState, 8'h00);
    rstN = 1'b1; waitQ(20);
    startCond();
    writeByte({7'h4E, 1'b1}, a1);
    readByte(1'b1, rd);
    stopCond();
    check("R1 readback after reset", rd, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule